// File: doc/BRIEF.md
# Dragonfly Route Computation Unit

This unit computes the next output port for a packet at one router of a dragonfly network. Routers are grouped: each group holds `A_RTR` routers, each router serves `P_TERM` terminal nodes and owns `H_GLB` global links. Routers inside a group are fully connected by local links. There are `A_RTR*H_GLB+1` groups, and they are fully connected by global links. Each router calls the unit once per hop. The unit receives the packet's destination node, its routing mode, its phase bit and the intermediate group carried in its header. It returns the output port, the updated phase bit and the intermediate group to write back into the header.

Two modes exist. In minimal mode a packet moves local, global, local, so it needs at most three hops. In misrouting mode the router where the packet is injected draws a random intermediate group from a 16-bit LFSR. The packet is routed minimally to that group, its phase bit is then set, and it is routed minimally to the destination. This gives at most five hops. A draw that equals the current group or the destination group is discarded and drawn again on the next cycle.

The control is a three-state machine. IDLE waits for `req_valid`. From IDLE, a misrouting request with `req_inject` set moves to DRAW and any other request moves to RESP. DRAW steps the LFSR each cycle and moves to RESP on the first acceptable draw. RESP presents the result for one cycle and always returns to IDLE.

Top module: `dfly_route_unit`

## Requirements
- R1: After reset, `resp_valid` is low, and it stays low while no request is given.
- R2: When the destination group and router equal the current ones, the port equals the destination terminal index (ports 0 to P_TERM-1). The destination node identifier is {group, router, terminal}, with the terminal in the low $clog2(P_TERM) bits and the router in the next $clog2(A_RTR) bits.
- R3: In the destination group, at a different router d, with current router c, the port is P_TERM + d when d < c, and P_TERM + d - 1 otherwise.
- R4: Global link j of group x leads to group (x+j+1) mod GRPS and belongs to router j / H_GLB as its link j mod H_GLB. Global link k of a router is port P_TERM+A_RTR-1+k. For a target group t different from x, j = (t-x-1) mod GRPS. If the current router owns j, the port is that global port.
- R5: If the current router does not own link j, the port is the local port (by the R3 numbering) to the router that owns it.
- R6: In minimal mode the target group is the destination group. `resp_phase` is 1 and `resp_inter` echoes `req_inter`. `resp_valid` rises in the cycle after the request is accepted and lasts exactly one cycle.
- R7: In misrouting mode with `req_inject`=1, `req_phase` is ignored. The returned intermediate group is below GRPS, differs from the current group and differs from the destination group. `resp_phase` is 0, and the port routes toward the intermediate group.
- R8: In misrouting mode with phase 0, if the current group equals `req_inter`, `resp_phase` becomes 1 and routing targets the destination group.
- R9: In misrouting mode with phase 0, away from the intermediate group, routing targets `req_inter`, and phase 0 and `req_inter` are returned.
- R10: In misrouting mode with phase 1, routing targets the destination group and `resp_phase` stays 1.
- R11: A misrouting injection whose destination lies in the current group still draws an intermediate group different from the current group.
- R12: Following the ports hop by hop delivers the packet to its destination node within 3 router-to-router hops in minimal mode and within 5 in misrouting mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_group | input | GW | Group index of this router |
| cur_router | input | RW | Router index within its group |
| req_valid | input | 1 | Request strobe, one cycle, given only while idle |
| req_dst | input | NW | Destination node {group, router, terminal} |
| req_valiant | input | 1 | 1 selects misrouting via an intermediate group, 0 selects minimal |
| req_inject | input | 1 | Packet enters the network at this router |
| req_phase | input | 1 | Header phase bit: intermediate group already reached |
| req_inter | input | GW | Header intermediate group |
| resp_valid | output | 1 | Result valid for one cycle |
| resp_port | output | PW | Selected output port |
| resp_phase | output | 1 | Updated phase bit |
| resp_inter | output | GW | Intermediate group to carry onward |

## Verification
The assertions assume three things about the inputs. A request arrives only while the unit is idle. Group fields of `req_dst` and `req_inter` are below GRPS. `cur_group` and `cur_router` stay constant while a request is in progress. The bench keeps to all three. It sends a request only after the previous response has been taken. It builds every node identifier from in-range group, router and terminal indices, and it holds the router position fixed until each response returns. Values drawn from the LFSR are not predicted exactly. They are checked for their exclusion rules, and the port is checked against the group that was actually drawn.

// File: rtl/dfly_pkg.sv
package dfly_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DRAW = 2'd1,
        ST_RESP = 2'd2
    } rc_state_e;

    localparam logic [15:0] LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/dfly_lfsr.sv
module dfly_lfsr #(
    parameter int W = 16,
    parameter logic [W-1:0] SEED = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);
    logic [W-1:0] q;
    logic         fb;

    // taps for x^16 + x^14 + x^13 + x^11 + 1
    assign fb = q[W-1] ^ q[W-3] ^ q[W-4] ^ q[W-6];

    always_ff @(posedge clk) begin
        if (!rst_n) q <= SEED;
        else        q <= {q[W-2:0], fb};
    end

    assign value = q;

    assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q != '0);
endmodule

// File: rtl/dfly_port_sel.sv
module dfly_port_sel #(
    parameter int P_TERM = 2,
    parameter int A_RTR  = 4,
    parameter int H_GLB  = 2,
    localparam int GRPS  = A_RTR * H_GLB + 1,
    localparam int TW    = $clog2(P_TERM),
    localparam int RW    = $clog2(A_RTR),
    localparam int GW    = $clog2(GRPS),
    localparam int NPORT = P_TERM + A_RTR - 1 + H_GLB,
    localparam int PW    = $clog2(NPORT)
) (
    input  logic [GW-1:0] here_grp,
    input  logic [RW-1:0] here_rtr,
    input  logic [GW-1:0] goal_grp,
    input  logic [RW-1:0] goal_rtr,
    input  logic [TW-1:0] goal_term,
    output logic [PW-1:0] port
);
    localparam int LOC_BASE = P_TERM;
    localparam int GLB_BASE = P_TERM + A_RTR - 1;

    function automatic int local_port(input int peer, input int self);
        return LOC_BASE + ((peer < self) ? peer : peer - 1);
    endfunction

    int link_j;
    int owner;
    int sel;

    always_comb begin
        link_j = int'(goal_grp) + GRPS - 1 - int'(here_grp);
        if (link_j >= GRPS) link_j = link_j - GRPS;
        owner = link_j / H_GLB;
        if (goal_grp == here_grp) begin
            if (goal_rtr == here_rtr) sel = int'(goal_term);
            else                      sel = local_port(int'(goal_rtr), int'(here_rtr));
        end else if (owner == int'(here_rtr)) begin
            sel = GLB_BASE + (link_j % H_GLB);
        end else begin
            sel = local_port(owner, int'(here_rtr));
        end
        port = PW'(sel);
    end
endmodule

// File: rtl/dfly_route_unit.sv
module dfly_route_unit
    import dfly_pkg::*;
#(
    parameter int P_TERM = 2,
    parameter int A_RTR  = 4,
    parameter int H_GLB  = 2,
    localparam int GRPS  = A_RTR * H_GLB + 1,
    localparam int TW    = $clog2(P_TERM),
    localparam int RW    = $clog2(A_RTR),
    localparam int GW    = $clog2(GRPS),
    localparam int NW    = GW + RW + TW,
    localparam int NPORT = P_TERM + A_RTR - 1 + H_GLB,
    localparam int PW    = $clog2(NPORT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [GW-1:0] cur_group,
    input  logic [RW-1:0] cur_router,
    input  logic          req_valid,
    input  logic [NW-1:0] req_dst,
    input  logic          req_valiant,
    input  logic          req_inject,
    input  logic          req_phase,
    input  logic [GW-1:0] req_inter,
    output logic          resp_valid,
    output logic [PW-1:0] resp_port,
    output logic          resp_phase,
    output logic [GW-1:0] resp_inter
);
    rc_state_e     state_q, state_d;
    logic [NW-1:0] dst_q;
    logic          val_q, inj_q, phase_q;
    logic [GW-1:0] inter_q;
    logic [15:0]   rnd;
    logic [GW-1:0] cand;
    logic          cand_ok;
    logic [GW-1:0] dst_grp;
    logic [RW-1:0] dst_rtr;
    logic [TW-1:0] dst_term;
    logic [GW-1:0] goal_grp;
    logic          phase_out;

    assign dst_grp  = dst_q[NW-1 -: GW];
    assign dst_rtr  = dst_q[TW +: RW];
    assign dst_term = dst_q[0 +: TW];

    dfly_lfsr #(.W(16), .SEED(LFSR_SEED)) rng_i (
        .clk(clk), .rst_n(rst_n), .value(rnd)
    );

    assign cand    = GW'(int'(rnd) % GRPS);
    assign cand_ok = (cand != cur_group) && (cand != dst_grp);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = (req_valiant && req_inject) ? ST_DRAW : ST_RESP;
            ST_DRAW: if (cand_ok)   state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture and intermediate group draw
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_q   <= '0;
            val_q   <= 1'b0;
            inj_q   <= 1'b0;
            phase_q <= 1'b0;
            inter_q <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            dst_q   <= req_dst;
            val_q   <= req_valiant;
            inj_q   <= req_inject;
            phase_q <= req_phase && !req_inject;
            inter_q <= req_inter;
        end else if (state_q == ST_DRAW && cand_ok) begin
            inter_q <= cand;
        end
    end

    // target group and phase update
    always_comb begin
        if (!val_q || phase_q || (cur_group == inter_q)) begin
            goal_grp  = dst_grp;
            phase_out = 1'b1;
        end else begin
            goal_grp  = inter_q;
            phase_out = 1'b0;
        end
    end

    dfly_port_sel #(.P_TERM(P_TERM), .A_RTR(A_RTR), .H_GLB(H_GLB)) sel_i (
        .here_grp (cur_group),
        .here_rtr (cur_router),
        .goal_grp (goal_grp),
        .goal_rtr (dst_rtr),
        .goal_term(dst_term),
        .port     (resp_port)
    );

    // outputs
    always_comb begin
        resp_valid = (state_q == ST_RESP);
        resp_phase = phase_out;
        resp_inter = inter_q;
    end

    // input contract: requests only while idle
    assert_req_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> state_q == ST_IDLE);
    assert_resp_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
    assert_min_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(req_valiant && req_inject)) |=> resp_valid);
    assert_inter_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && val_q && inj_q) |-> (resp_inter != cur_group && resp_inter != dst_grp
                                            && int'(resp_inter) < GRPS));
    assert_inject_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && val_q && inj_q) |-> !resp_phase);
    assert_phase_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && val_q && !inj_q && phase_q) |-> resp_phase);
    assert_port_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> int'(resp_port) < NPORT);
    assert_term_only_home_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && int'(resp_port) < P_TERM) |-> (cur_group == dst_grp && cur_router == dst_rtr));
endmodule

// File: tb/dfly_route_unit_tb_top.sv
module dfly_route_unit_tb_top;
    localparam int P = 2, A = 4, H = 2;
    localparam int G  = A * H + 1;
    localparam int TW = $clog2(P), RW = $clog2(A), GW = $clog2(G);
    localparam int NW = GW + RW + TW;
    localparam int K  = P + A - 1 + H;
    localparam int PW = $clog2(K);

    logic clk = 1'b0, rst_n = 1'b0;
    logic [GW-1:0] cur_group = '0;
    logic [RW-1:0] cur_router = '0;
    logic req_valid = 1'b0, req_valiant = 1'b0, req_inject = 1'b0, req_phase = 1'b0;
    logic [NW-1:0] req_dst = '0;
    logic [GW-1:0] req_inter = '0;
    logic resp_valid, resp_phase;
    logic [PW-1:0] resp_port;
    logic [GW-1:0] resp_inter;

    always #5 clk = ~clk;

    dfly_route_unit #(.P_TERM(P), .A_RTR(A), .H_GLB(H)) dut_i (.*);

    typedef struct {
        int cg; int cr; int dst; bit rnd; int port; bit phase; int inter;
    } exp_t;
    exp_t sb[$];

    int checks = 0, errors = 0, issued = 0, popped = 0;
    int last_port, last_inter; bit last_phase;
    bit finished = 0;

    function automatic int node(int g, int r, int t);
        return (g << (TW + RW)) | (r << TW) | t;
    endfunction
    function automatic int grp_of(int n); return n >> (TW + RW); endfunction
    function automatic int rtr_of(int n); return (n >> TW) % A; endfunction
    function automatic int term_of(int n); return n % P; endfunction

    // expected port from the numbering rules of R2..R5
    function automatic int model_port(int cg, int cr, int tg, int dr, int dt);
        int j, own, peer;
        if (tg == cg) begin
            if (dr == cr) return dt;
            peer = dr;
        end else begin
            j = ((tg - cg - 1) % G + G) % G;
            own = j / H;
            if (own == cr) return P + A - 1 + (j % H);
            peer = own;
        end
        return (peer < cr) ? P + peer : P + peer - 1;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pop and compare at every response
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (sb.size() == 0) begin
                check(0, "R6 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.rnd) begin
                    check(int'(resp_inter) < G, "R7 inter range", int'(resp_inter), G - 1);
                    check(int'(resp_inter) != e.cg, "R7/R11 inter vs current group", int'(resp_inter), -1);
                    check(int'(resp_inter) != grp_of(e.dst), "R7 inter vs dest group", int'(resp_inter), -1);
                    check(resp_phase == 1'b0, "R7 phase", int'(resp_phase), 0);
                    e.port = model_port(e.cg, e.cr, int'(resp_inter), rtr_of(e.dst), term_of(e.dst));
                    check(int'(resp_port) == e.port, "R7 port toward intermediate", int'(resp_port), e.port);
                end else begin
                    check(int'(resp_port) == e.port, "R2-R5/R8-R10 port", int'(resp_port), e.port);
                    check(resp_phase == e.phase, "R6/R8/R9/R10 phase", int'(resp_phase), int'(e.phase));
                    check(int'(resp_inter) == e.inter, "R6/R9 inter echo", int'(resp_inter), e.inter);
                end
            end
            last_port = int'(resp_port); last_phase = resp_phase; last_inter = int'(resp_inter);
            popped++;
        end
    end

    // driver: push expectation, issue request, wait for its response
    task automatic send(int cg, int cr, int dst, bit val, bit inj, bit ph, int it);
        exp_t e;
        int tg;
        bit ph_out;
        bit draw = val && inj;
        if (!val || (ph && !inj)) begin tg = grp_of(dst); ph_out = 1; end
        else if (cg == it) begin tg = grp_of(dst); ph_out = 1; end
        else begin tg = it; ph_out = 0; end
        e.cg = cg; e.cr = cr; e.dst = dst; e.rnd = draw; e.inter = it; e.phase = ph_out;
        e.port = model_port(cg, cr, tg, rtr_of(dst), term_of(dst));
        @(negedge clk);
        cur_group = GW'(cg); cur_router = RW'(cr);
        req_dst = NW'(dst); req_valiant = val; req_inject = inj;
        req_phase = ph; req_inter = GW'(it); req_valid = 1'b1;
        sb.push_back(e);
        issued++;
        @(negedge clk);
        req_valid = 1'b0;
        if (!draw) check(resp_valid == 1'b1, "R6 one-cycle latency", int'(resp_valid), 1);
        wait (popped == issued);
        @(negedge clk);
        check(resp_valid == 1'b0, "R6 single-cycle response", int'(resp_valid), 0);
    endtask

    // follow the chosen ports through the topology (R12)
    task automatic walk(int sg, int sr, int dst, bit val, int maxh);
        int cg = sg, cr = sr, it = 0, hops = 0;
        bit ph = 0, done = 0;
        for (int s = 0; s < 8 && !done; s++) begin
            send(cg, cr, dst, val, s == 0, ph, it);
            ph = last_phase; it = last_inter;
            if (last_port < P) begin
                done = 1;
                check(cg == grp_of(dst) && cr == rtr_of(dst) && last_port == term_of(dst),
                      "R12 delivered at destination", last_port, term_of(dst));
            end else if (last_port < P + A - 1) begin
                int idx = last_port - P;
                cr = (idx < cr) ? idx : idx + 1;
                hops++;
            end else begin
                int j = cr * H + (last_port - (P + A - 1));
                int ng = (cg + j + 1) % G;
                int jr = ((cg - ng - 1) % G + G) % G;
                cg = ng; cr = jr / H;
                hops++;
            end
        end
        check(done, "R12 delivery", int'(done), 1);
        check(hops <= maxh, "R12 hop bound", hops, maxh);
        if (val) check(ph == 1'b1, "R8 phase set before delivery", int'(ph), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(resp_valid == 1'b0, "R1 reset", int'(resp_valid), 0);
        rst_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check(resp_valid == 1'b0, "R1 idle", int'(resp_valid), 0);
        end
        // R2 terminal, R3 local in dest group, minimal mode R6
        send(3, 2, node(3, 2, 1), 0, 0, 0, 5);
        send(3, 2, node(3, 2, 0), 0, 0, 0, 0);
        send(3, 2, node(3, 0, 0), 0, 0, 0, 1);
        send(3, 2, node(3, 3, 1), 0, 0, 0, 7);
        // R4 owned global links, R5 via owner
        send(3, 2, node(8, 1, 0), 0, 0, 0, 2);
        send(3, 2, node(0, 3, 1), 0, 0, 0, 0);
        send(3, 2, node(4, 0, 0), 0, 0, 0, 4);
        send(3, 2, node(2, 2, 1), 0, 0, 0, 0);
        send(0, 0, node(1, 1, 1), 0, 0, 0, 0);
        send(8, 3, node(7, 0, 1), 0, 0, 0, 0);
        // R9 heading to intermediate, R8 at intermediate, R10 phase set
        send(3, 1, node(6, 0, 1), 1, 0, 0, 5);
        send(5, 0, node(6, 0, 1), 1, 0, 0, 5);
        send(5, 3, node(5, 3, 0), 1, 0, 0, 5);
        send(5, 0, node(6, 2, 1), 1, 0, 1, 2);
        // R7 injections, R7 with phase input set, R11 dest in same group
        send(1, 1, node(6, 3, 0), 1, 1, 0, 0);
        send(4, 0, node(2, 1, 1), 1, 1, 1, 4);
        send(7, 2, node(7, 0, 1), 1, 1, 0, 7);
        send(0, 3, node(0, 3, 0), 1, 1, 0, 0);
        // R12 walks
        walk(0, 0, node(5, 3, 1), 0, 3);
        walk(6, 3, node(2, 0, 0), 0, 3);
        walk(2, 1, node(2, 3, 1), 0, 3);
        walk(0, 0, node(5, 3, 1), 1, 5);
        walk(8, 2, node(1, 1, 0), 1, 5);
        walk(4, 0, node(4, 2, 1), 1, 5);
        for (int g = 0; g < G; g++) walk(g, g % A, node((g + 4) % G, (g + 1) % A, g % P), 1, 5);
        check(sb.size() == 0, "R6 all responses received", sb.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog R6 actual=%0d expected=%0d", popped, issued);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule